// File: doc/BRIEF.md
# Open-Drain Clock/Data Pin Pair Control Register

This block holds the control state for one two-wire serial line pair (a clock line and a data line) that software drives by bit-banging through a single register. Each line behaves as open-drain. To pull a line low, software sets its direction to drive and its output value to 0. To let a line float high, software sets its direction back to input, and the external pull-up takes the line high. The block never drives a 1 onto a released line.

Every writable field has a companion update bit in the same write word. A field changes only when its update bit is set in that write. This lets software move one line, or only one property of one line, without first reading the register back. The two pull-up disable controls share one update bit of their own, so ordinary line writes never disturb them.

On readback the register returns the stored direction, value and pull-up bits. It also returns the level of each pin, taken after a two-flop synchroniser. Software samples a pin by first writing its direction update with direction = input, then writing again with no update bit for that line, then reading the input bit.

Top module: `odpin_pair_reg`

## Requirements
- R1: After reset both lines have direction = input (pad output enable 0) and stored value 0, both pull-up disable outputs are 0, and every stored field reads back as 0.
- R2: Line L has base bit B (clock B=0, data B=8). Its direction field takes wr_data[B+1] (1 = drive) only when wr_data[B+0] is 1 in the same write. The new direction appears on the pad output enable in the cycle after the write edge.
- R3: A line's value field takes wr_data[B+3] only when wr_data[B+2] is 1 in the same write. The pad output value always equals the stored value.
- R4: A write with direction update = 1, direction = 1, value update = 1 and value = 0 pulls the line low: output enable 1, output value 0.
- R5: A write with only the direction update set and direction = 0 releases the line (output enable 0) and leaves its stored value unchanged.
- R6: Bit 17 (clock) and bit 18 (data) set the pull-up disable outputs only when bit 16 is 1 in the same write. Any other write leaves both unchanged.
- R7: Each pad input level passes through two flops and appears at read bit B+4 after the second rising edge following a change, never after the first.
- R8: Readback places direction at B+1, value at B+3, input at B+4, and pull-up disables at 17 and 18. Update bits and every other bit read 0.
- R9: A write that sets update bits for one line only leaves the other line's direction and value unchanged.
- R10: A cycle with wr_en low changes no stored field, whatever wr_data carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word carrying fields and update bits |
| rd_data | output | 32 | Register readback |
| ck_oe | output | 1 | Clock pad output enable (1 = drive) |
| ck_o | output | 1 | Clock pad output value |
| ck_i | input | 1 | Clock pad input level |
| dt_oe | output | 1 | Data pad output enable (1 = drive) |
| dt_o | output | 1 | Data pad output value |
| dt_i | input | 1 | Data pad input level |
| ck_pu_dis | output | 1 | Clock pull-up disable |
| dt_pu_dis | output | 1 | Data pull-up disable |

## Verification
The write sequence pairs each field value with its update bit both set and clear. A clear update bit with a differing value exposes a field that ignores its update bit, and a set update bit exposes a field that fails to load. Some writes touch only one property (direction or value) of one line, which separates a swapped or shared update bit between fields or between lines. A pad input change is sampled one and two edges later, which tells a correct two-stage path from one that is a stage short or a stage long. Pull-up writes with and without their update bit, mixed with all-ones line writes, show whether the sticky controls leak.

// File: rtl/odpin_pkg.sv
package odpin_pkg;
    localparam int REG_W       = 32;
    localparam int NUM_LINES   = 2;
    localparam int LINE_STRIDE = 8;
    localparam int OFS_DIR_WE  = 0;
    localparam int OFS_DIR     = 1;
    localparam int OFS_VAL_WE  = 2;
    localparam int OFS_VAL     = 3;
    localparam int OFS_IN      = 4;
    localparam int PU_WE_BIT   = 16;
    localparam int PU_BASE     = 17;

    typedef struct packed {
        logic [NUM_LINES-1:0] dir;
        logic [NUM_LINES-1:0] val;
        logic [NUM_LINES-1:0] pu;
    } pin_state_t;

    function automatic int line_base(int l);
        return l * LINE_STRIDE;
    endfunction
endpackage

// File: rtl/odpin_line_next.sv
module odpin_line_next (
    input  logic cur_dir,
    input  logic cur_val,
    input  logic wr_en,
    input  logic dir_we,
    input  logic dir_in,
    input  logic val_we,
    input  logic val_in,
    output logic nxt_dir,
    output logic nxt_val
);
    always_comb begin
        nxt_dir = cur_dir;
        nxt_val = cur_val;
        if (wr_en && dir_we) begin
            nxt_dir = dir_in;
        end
        if (wr_en && val_we) begin
            nxt_val = val_in;
        end
    end
endmodule

// File: rtl/odpin_sync.sv
module odpin_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= stage_d[s];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/odpin_pair_reg.sv
module odpin_pair_reg
    import odpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             ck_oe,
    output logic             ck_o,
    input  logic             ck_i,
    output logic             dt_oe,
    output logic             dt_o,
    input  logic             dt_i,
    output logic             ck_pu_dis,
    output logic             dt_pu_dis
);
    localparam int LIDX_CK = 0;
    localparam int LIDX_DT = 1;

    pin_state_t state_d, state_q;
    logic [NUM_LINES-1:0] nxt_dir, nxt_val;
    logic [NUM_LINES-1:0] pad_in, pad_sync;

    assign pad_in[LIDX_CK] = ck_i;
    assign pad_in[LIDX_DT] = dt_i;

    generate
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            localparam int B = l * LINE_STRIDE;
            odpin_line_next u_next (
                .cur_dir (state_q.dir[l]),
                .cur_val (state_q.val[l]),
                .wr_en   (wr_en),
                .dir_we  (wr_data[B+OFS_DIR_WE]),
                .dir_in  (wr_data[B+OFS_DIR]),
                .val_we  (wr_data[B+OFS_VAL_WE]),
                .val_in  (wr_data[B+OFS_VAL]),
                .nxt_dir (nxt_dir[l]),
                .nxt_val (nxt_val[l])
            );
        end
    endgenerate

    odpin_sync #(.STAGES(SYNC_STAGES), .W(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    always_comb begin
        state_d     = state_q;
        state_d.dir = nxt_dir;
        state_d.val = nxt_val;
        if (wr_en && wr_data[PU_WE_BIT]) begin
            state_d.pu = wr_data[PU_BASE +: NUM_LINES];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            rd_data[line_base(l)+OFS_DIR] = state_q.dir[l];
            rd_data[line_base(l)+OFS_VAL] = state_q.val[l];
            rd_data[line_base(l)+OFS_IN]  = pad_sync[l];
        end
        rd_data[PU_BASE +: NUM_LINES] = state_q.pu;
    end

    assign ck_oe     = state_q.dir[LIDX_CK];
    assign ck_o      = state_q.val[LIDX_CK];
    assign dt_oe     = state_q.dir[LIDX_DT];
    assign dt_o      = state_q.val[LIDX_DT];
    assign ck_pu_dis = state_q.pu[LIDX_CK];
    assign dt_pu_dis = state_q.pu[LIDX_DT];
endmodule

// File: rtl/odpin_pair_chk.sv
module odpin_pair_chk
    import odpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             ck_oe,
    input logic             ck_o,
    input logic             ck_i,
    input logic             dt_oe,
    input logic             dt_o,
    input logic             dt_i,
    input logic             ck_pu_dis,
    input logic             dt_pu_dis
);
    localparam logic [REG_W-1:0] RD_LEGAL = 32'h0006_1A1A;
    logic [7:0] edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges_q <= '0;
        end else if (edges_q != 8'hFF) begin
            edges_q <= edges_q + 8'd1;
        end
    end

    // R2 / R10: clock direction moves only with its update bit
    a_r2_ck_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[OFS_DIR_WE]) |=> $stable(ck_oe));
    a_r2_ck_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[OFS_DIR_WE]) |=> ck_oe == $past(wr_data[OFS_DIR]));
    a_r2_dt_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[LINE_STRIDE+OFS_DIR_WE]) |=> $stable(dt_oe));
    // R3: value fields
    a_r3_ck_val_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[OFS_VAL_WE]) |=> $stable(ck_o));
    a_r3_dt_val_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[LINE_STRIDE+OFS_VAL_WE]) |=> dt_o == $past(wr_data[LINE_STRIDE+OFS_VAL]));
    // R6: pull-up disables are sticky
    a_r6_pu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[PU_WE_BIT]) |=> ($stable(ck_pu_dis) && $stable(dt_pu_dis)));
    // R7: two-flop input path
    a_r7_ck_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q >= 8'(SYNC_STAGES)) |-> rd_data[OFS_IN] == $past(ck_i, SYNC_STAGES));
    a_r7_dt_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q >= 8'(SYNC_STAGES)) |-> rd_data[LINE_STRIDE+OFS_IN] == $past(dt_i, SYNC_STAGES));
    // R8: nothing outside the readable fields
    a_r8_rd_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~RD_LEGAL) == '0);
    // R8: readback agrees with pads
    a_r8_rd_pads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[OFS_DIR] == ck_oe) && (rd_data[LINE_STRIDE+OFS_VAL] == dt_o)
        && (rd_data[PU_BASE] == ck_pu_dis));
endmodule

bind odpin_pair_reg odpin_pair_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .ck_oe     (ck_oe),
    .ck_o      (ck_o),
    .ck_i      (ck_i),
    .dt_oe     (dt_oe),
    .dt_o      (dt_o),
    .dt_i      (dt_i),
    .ck_pu_dis (ck_pu_dis),
    .dt_pu_dis (dt_pu_dis)
);

// File: tb/tb_odpin_pair_reg.sv
`timescale 1ns/1ps
module tb_odpin_pair_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ck_oe, ck_o, dt_oe, dt_o, ck_pu_dis, dt_pu_dis;
    logic        ck_i = 1'b0;
    logic        dt_i = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    odpin_pair_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ck_oe(ck_oe), .ck_o(ck_o), .ck_i(ck_i), .dt_oe(dt_oe), .dt_o(dt_o), .dt_i(dt_i),
        .ck_pu_dis(ck_pu_dis), .dt_pu_dis(dt_pu_dis)
    );

    // {write word, expected ck_oe, ck_o, dt_oe, dt_o}
    localparam logic [35:0] VEC [12] = '{
        {32'h0000_000F, 4'b1100},  // R2 R3 both loaded
        {32'h0000_0005, 4'b0000},  // R2 R3 cleared
        {32'h0000_000B, 4'b1000},  // R3 value ignored without update bit
        {32'h0000_0001, 4'b0000},  // R5 release
        {32'h0000_0707, 4'b1010},  // R4 both pulled low
        {32'h0000_000C, 4'b1110},  // R3 value alone, R9
        {32'h0000_0A0A, 4'b1110},  // R2 R3 no update bits
        {32'h0000_0100, 4'b1100},  // R5 R9 data released
        {32'h0000_0C00, 4'b1101},  // R3 data value
        {32'h0000_0001, 4'b0101},  // R5 R9 clock release keeps value
        {32'h0000_0006, 4'b0001},  // R3 value without direction
        {32'h0000_0505, 4'b0000}   // R2 R3 both cleared
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    function automatic logic [31:0] exp_rd(input logic [3:0] p, input logic [1:0] pu, input logic [1:0] pin);
        return (32'(p[3]) << 1) | (32'(p[2]) << 3) | (32'(p[1]) << 9) | (32'(p[0]) << 11)
             | (32'(pin[0]) << 4) | (32'(pin[1]) << 12) | (32'(pu) << 17);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [3:0] pads;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({ck_oe, ck_o, dt_oe, dt_o, ck_pu_dis, dt_pu_dis} == 6'b0, "R1 pads in reset",
              {26'b0, ck_oe, ck_o, dt_oe, dt_o, ck_pu_dis, dt_pu_dis}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 32'h0, "R1 readback after reset", rd_data, 32'h0);

        for (int i = 0; i < 12; i++) begin
            write(VEC[i][35:4]);
            pads = {ck_oe, ck_o, dt_oe, dt_o};
            check(pads == VEC[i][3:0], $sformatf("R2/R3 vector %0d pads", i), 32'(pads), 32'(VEC[i][3:0]));
            check(rd_data == exp_rd(VEC[i][3:0], 2'b00, 2'b00), $sformatf("R8 vector %0d readback", i),
                  rd_data, exp_rd(VEC[i][3:0], 2'b00, 2'b00));
        end

        // R10: strobe low with busy data
        @(negedge clk);
        wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_data = '0;
        check(rd_data == 32'h0, "R10 no strobe no change", rd_data, 32'h0);

        // R6 pull-up controls
        write(32'h0002_0000);
        check({dt_pu_dis, ck_pu_dis} == 2'b00, "R6 no update bit", 32'({dt_pu_dis, ck_pu_dis}), 32'h0);
        write(32'h0003_0000);
        check({dt_pu_dis, ck_pu_dis} == 2'b01, "R6 clock pull-up set", 32'({dt_pu_dis, ck_pu_dis}), 32'h1);
        write(32'h0000_070F);
        check({dt_pu_dis, ck_pu_dis} == 2'b01, "R6 sticky across line write", 32'({dt_pu_dis, ck_pu_dis}), 32'h1);
        check({ck_oe, ck_o, dt_oe, dt_o} == 4'b1110, "R4 data pulled low", 32'({ck_oe, ck_o, dt_oe, dt_o}), 32'hE);
        write(32'h0005_0000);
        check(rd_data == exp_rd(4'b1110, 2'b10, 2'b00), "R6 data pull-up readback",
              rd_data, exp_rd(4'b1110, 2'b10, 2'b00));

        // R7 sync latency, clock line
        write(32'h0000_0101);
        @(negedge clk);
        ck_i = 1'b1;
        @(negedge clk);
        check(rd_data[4] == 1'b0, "R7 clock not visible after one edge", 32'(rd_data[4]), 32'h0);
        @(negedge clk);
        check(rd_data[4] == 1'b1, "R7 clock visible after two edges", 32'(rd_data[4]), 32'h1);
        dt_i = 1'b1;
        @(negedge clk);
        check(rd_data[12] == 1'b0, "R7 data not visible after one edge", 32'(rd_data[12]), 32'h0);
        @(negedge clk);
        check(rd_data[12] == 1'b1, "R7 data visible after two edges", 32'(rd_data[12]), 32'h1);

        // R8 all-ones write
        write(32'hFFFF_FFFF);
        check(rd_data == 32'h0006_1A1A, "R8 all-ones readback", rd_data, 32'h0006_1A1A);
        ck_i = 1'b0;
        repeat (2) @(negedge clk);
        check(rd_data == 32'h0006_1A0A, "R7 R8 clock input falls", rd_data, 32'h0006_1A0A);

        // R9 clock-only update leaves data
        write(32'h0000_0005);
        check({ck_oe, ck_o, dt_oe, dt_o} == 4'b0011, "R9 data untouched", 32'({ck_oe, ck_o, dt_oe, dt_o}), 32'h3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule